// File: doc/BRIEF.md
# Ticket-Ordered Queue Lock Unit

This block arbitrates one lock among a set of requesters and hands it over strictly in arrival order. A requester raises its acquire line; in the cycle the unit accepts it, the unit raises that requester's acknowledge and returns a ticket taken from a wrapping tail counter, and the counter advances. A ring of flag slots, one per possible ticket holder, records which slot currently owns the lock. A requester is granted when the slot picked by the low bits of its ticket is set. Each waiter therefore depends on its own slot only, and no shared lock word is involved.

When the current owner pulses release, its own slot is cleared and the following slot is set. The requester that holds the next ticket sees its grant one cycle later. Acquires that arrive together are ranked by requester index and receive consecutive tickets. The number of tickets held at once is capped at the ring size, and acquires beyond that cap wait. A release from a requester that does not own the lock changes nothing and raises an error pulse.

Top module: `qlock_unit`

## Requirements
- R1: After reset only slot 0 is set and the tail counter is 0, so the first accepted acquire returns ticket 0 and is granted in the cycle after its acknowledge.
- R2: An accepted acquire raises `acq_ack` for that requester in the same cycle, with `ticket_o` carrying the tail value. The tail then advances by one per accepted acquire and wraps modulo 2^TICKET_W.
- R3: Acquires accepted in the same cycle are ranked from the lowest requester index upward and receive consecutive tickets in that order.
- R4: A ticket holder is granted exactly when the flag slot at (ticket mod SLOTS), the low bits of the ticket, is set. This holds across tail wrap.
- R5: A release from the granted requester clears its slot and sets the next slot (mod SLOTS). The holder of the following ticket is granted in the cycle after the release is sampled.
- R6: Grants are issued in ticket order, first come first served.
- R7: At most SLOTS tickets are outstanding. The count is taken at the start of the cycle, and an acquire that would exceed it gets no acknowledge until a release lowers the count.
- R8: A release from a requester that is not granted has no effect on any slot or grant, and it raises `rel_err` in the same cycle.
- R9: An acquire from a requester that already holds a ticket is ignored and gets no acknowledge.
- R10: At most one requester is granted at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | NREQ | Per-requester acquire request, held until acknowledged |
| acq_ack | output | NREQ | Per-requester acquire accepted this cycle |
| ticket_o | output | NREQ*TICKET_W | Per-requester ticket, valid while its acq_ack is high |
| grant | output | NREQ | Per-requester lock ownership |
| rel | input | NREQ | Per-requester release pulse |
| rel_err | output | 1 | A release came from a requester without the lock |

## Verification
A corrupted flag ring shows up at `grant` in the cycle after the fault. A lost flag leaves every later waiter ungranted, and a second set flag grants two requesters at once. A wrong tail or rank value appears on `ticket_o` in the acknowledge cycle itself. It then puts grants out of arrival order at the next handover. A stale outstanding count either refuses an acquire that should be acknowledged or acknowledges one beyond the ring size, and the difference is visible on `acq_ack` in the same cycle.

// File: rtl/qlock_pkg.sv
package qlock_pkg;

  // slot index selected by a ticket; slots is a power of two
  function automatic int slot_of(int ticket, int slots);
    return ticket & (slots - 1);
  endfunction

  // slot that follows a given slot around the ring
  function automatic int next_slot(int slot, int slots);
    return (slot + 1) & (slots - 1);
  endfunction

endpackage

// File: rtl/qlock_ticketer.sv
module qlock_ticketer #(
  parameter int NREQ     = 6,
  parameter int SLOTS    = 4,
  parameter int TICKET_W = 4,
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          acq_req,
  input  logic [NREQ-1:0]          holding,
  input  logic                     rel_ok,
  output logic [NREQ-1:0]          accept,
  output logic [NREQ*TICKET_W-1:0] tickets,
  output logic [CNT_W-1:0]         outstanding
);

  logic [TICKET_W-1:0] tail_q;
  logic [CNT_W-1:0]    out_q;
  logic [CNT_W-1:0]    n_acc;
  int                  rank;

  // fixed-priority serialization: lowest index ranks first
  always_comb begin
    rank    = 0;
    accept  = '0;
    tickets = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (acq_req[i] && !holding[i] && ((int'(out_q) + rank) < SLOTS)) begin
        accept[i] = 1'b1;
        tickets[i*TICKET_W +: TICKET_W] = tail_q + TICKET_W'(rank);
        rank = rank + 1;
      end
    end
    n_acc = CNT_W'(rank);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= '0;
      out_q  <= '0;
    end else begin
      tail_q <= tail_q + TICKET_W'(n_acc);
      out_q  <= out_q + n_acc - CNT_W'(rel_ok);
    end
  end

  assign outstanding = out_q;

endmodule

// File: rtl/qlock_flag_ring.sv
module qlock_flag_ring #(
  parameter int SLOTS   = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_ok,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic [SLOTS-1:0]  flags
);

  logic [SLOTS-1:0]  flags_q;
  logic [SLOTS-1:0]  clr_m;
  logic [SLOTS-1:0]  set_m;
  logic [SLOT_W-1:0] nxt_slot;

  always_comb begin
    nxt_slot = SLOT_W'(qlock_pkg::next_slot(int'(rel_slot), SLOTS));
    clr_m = '0;
    set_m = '0;
    clr_m[rel_slot] = 1'b1;
    set_m[nxt_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= SLOTS'(1);
    end else if (rel_ok) begin
      flags_q <= (flags_q & ~clr_m) | set_m;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/qlock_holder.sv
module qlock_holder #(
  parameter int TICKET_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [TICKET_W-1:0] ticket_in,
  input  logic                drop,
  output logic                holding,
  output logic [TICKET_W-1:0] ticket_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holding  <= 1'b0;
      ticket_q <= '0;
    end else if (take) begin
      holding  <= 1'b1;
      ticket_q <= ticket_in;
    end else if (drop) begin
      holding  <= 1'b0;
    end
  end

endmodule

// File: rtl/qlock_unit.sv
module qlock_unit #(
  parameter int NREQ     = 6,
  parameter int SLOTS    = 4,
  parameter int TICKET_W = 4,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          acq_req,
  output logic [NREQ-1:0]          acq_ack,
  output logic [NREQ*TICKET_W-1:0] ticket_o,
  output logic [NREQ-1:0]          grant,
  input  logic [NREQ-1:0]          rel,
  output logic                     rel_err
);

  logic [NREQ-1:0]     holding;
  logic [NREQ-1:0]     rel_valid;
  logic                rel_ok;
  logic [SLOT_W-1:0]   rel_slot;
  logic [SLOTS-1:0]    flags;
  logic [CNT_W-1:0]    outstanding;
  logic [TICKET_W-1:0] held_tk [NREQ];
  logic [SLOT_W-1:0]   slot_w  [NREQ];

  qlock_ticketer #(.NREQ(NREQ), .SLOTS(SLOTS), .TICKET_W(TICKET_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .holding(holding),
    .rel_ok(rel_ok), .accept(acq_ack), .tickets(ticket_o),
    .outstanding(outstanding)
  );

  qlock_flag_ring #(.SLOTS(SLOTS)) u_ring (
    .clk(clk), .rst_n(rst_n), .rel_ok(rel_ok), .rel_slot(rel_slot),
    .flags(flags)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    qlock_holder #(.TICKET_W(TICKET_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .take(acq_ack[g]),
      .ticket_in(ticket_o[g*TICKET_W +: TICKET_W]), .drop(rel_valid[g]),
      .holding(holding[g]), .ticket_q(held_tk[g])
    );
    assign slot_w[g]    = SLOT_W'(qlock_pkg::slot_of(int'(held_tk[g]), SLOTS));
    assign grant[g]     = holding[g] & flags[slot_w[g]];
    assign rel_valid[g] = rel[g] & grant[g];
  end

  assign rel_ok  = |rel_valid;
  assign rel_err = |(rel & ~grant);

  always_comb begin
    rel_slot = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (rel_valid[i]) rel_slot = rel_slot | slot_w[i];
    end
  end

endmodule

// File: rtl/qlock_unit_chk.sv
module qlock_unit_chk #(
  parameter int NREQ  = 6,
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  acq_req,
  input logic [NREQ-1:0]  acq_ack,
  input logic [NREQ-1:0]  holding,
  input logic [NREQ-1:0]  grant,
  input logic             rel_ok,
  input logic             rel_err,
  input logic [SLOTS-1:0] flags,
  input logic [CNT_W-1:0] outstanding
);

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R1
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(flags));

  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok |=> flags == {$past(flags[SLOTS-2:0]), $past(flags[SLOTS-1])});

  // R8
  bad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_err && !rel_ok) |=> $stable(flags));

  // R7
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) <= SLOTS);

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ack & ~acq_req) == '0);

  // R9
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_ack & holding) == '0);

endmodule

bind qlock_unit qlock_unit_chk #(.NREQ(NREQ), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .acq_ack(acq_ack),
  .holding(holding), .grant(grant), .rel_ok(rel_ok), .rel_err(rel_err),
  .flags(flags), .outstanding(outstanding)
);

// File: tb/qlock_unit_tb.sv
module qlock_unit_tb;
  localparam int N  = 6;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  acq_req = '0;
  logic [N-1:0]  rel = '0;
  logic [N-1:0]  acq_ack;
  logic [N*TW-1:0] ticket_o;
  logic [N-1:0]  grant;
  logic          rel_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  int exp_tk = 0;

  always #4 clk = ~clk;

  qlock_unit #(.NREQ(N), .SLOTS(4), .TICKET_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .acq_ack(acq_ack),
    .ticket_o(ticket_o), .grant(grant), .rel(rel), .rel_err(rel_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {acq, rel, exp_ack, exp_grant, exp_err}, checked before the rising edge
  localparam logic [24:0] VEC [16] = '{
    {6'b000001, 6'b000000, 6'b000001, 6'b000000, 1'b0}, // R1 ticket 0
    {6'b000000, 6'b000000, 6'b000000, 6'b000001, 1'b0}, // R1 grant next cycle
    {6'b000110, 6'b000000, 6'b000110, 6'b000001, 1'b0}, // R3 two at once
    {6'b111000, 6'b000000, 6'b001000, 6'b000001, 1'b0}, // R7 cap reached
    {6'b110000, 6'b000100, 6'b000000, 6'b000001, 1'b1}, // R8 bad release
    {6'b110000, 6'b000001, 6'b000000, 6'b000001, 1'b0}, // R5 R7 still full
    {6'b110000, 6'b000000, 6'b010000, 6'b000010, 1'b0}, // R5 handover, R7 room
    {6'b100000, 6'b000000, 6'b000000, 6'b000010, 1'b0}, // R7 full again
    {6'b100000, 6'b000010, 6'b000000, 6'b000010, 1'b0},
    {6'b100000, 6'b000000, 6'b100000, 6'b000100, 1'b0}, // R6 order
    {6'b000000, 6'b000100, 6'b000000, 6'b000100, 1'b0},
    {6'b000000, 6'b000000, 6'b000000, 6'b001000, 1'b0}, // R6
    {6'b000000, 6'b001000, 6'b000000, 6'b001000, 1'b0},
    {6'b000000, 6'b010000, 6'b000000, 6'b010000, 1'b0}, // R4 slot wraps to 0
    {6'b000000, 6'b100000, 6'b000000, 6'b100000, 1'b0}, // R4 slot 1
    {6'b000000, 6'b000000, 6'b000000, 6'b000000, 1'b0}
  };

  task automatic check_tickets(string req);
    for (int i = 0; i < N; i++) begin
      if (acq_ack[i]) begin
        chk(req, "ticket", 32'(ticket_o[i*TW +: TW]), 32'(exp_tk % 16));
        exp_tk++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "grant in reset", 32'(grant), 0);
    rst_n = 1'b1;

    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      acq_req = VEC[s][24:19];
      rel     = VEC[s][18:13];
      #1;
      chk("R2", "ack", 32'(acq_ack), 32'(VEC[s][12:7]));
      chk("R6", "grant", 32'(grant), 32'(VEC[s][6:1]));
      chk("R8", "rel_err", 32'(rel_err), 32'(VEC[s][0]));
      check_tickets("R3");
    end
    @(negedge clk);
    acq_req = '0; rel = '0;

    // R2 R4: tickets wrap past 15, slots keep following low bits
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      acq_req = 6'b000001;
      #1;
      chk("R2", "wrap ack", 32'(acq_ack), 1);
      check_tickets("R2");
      @(negedge clk);
      acq_req = '0;
      #1;
      chk("R4", "wrap grant", 32'(grant), 1);
      rel = 6'b000001;
      #1;
      chk("R8", "good release err", 32'(rel_err), 0);
      @(negedge clk);
      rel = '0;
      #1;
      chk("R5", "released", 32'(grant), 0);
    end

    // R9: acquire while holding is ignored
    @(negedge clk);
    acq_req = 6'b000100;
    #1;
    check_tickets("R9");
    @(negedge clk);
    #1;
    chk("R9", "reacquire ack", 32'(acq_ack), 0);
    chk("R9", "still granted", 32'(grant), 32'(6'b000100));
    acq_req = '0;
    // R8: release from an idle requester leaves the holder alone
    rel = 6'b010000;
    #1;
    chk("R8", "idle release err", 32'(rel_err), 1);
    @(negedge clk);
    rel = '0;
    #1;
    chk("R8", "holder kept", 32'(grant), 32'(6'b000100));

    // R1: reset mid-run restores slot 0 and ticket 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "grant after reset", 32'(grant), 0);
    rst_n = 1'b1;
    exp_tk = 0;
    @(negedge clk);
    acq_req = 6'b001000;
    #1;
    chk("R1", "ack after reset", 32'(acq_ack), 32'(6'b001000));
    check_tickets("R1");
    @(negedge clk);
    acq_req = '0;
    #1;
    chk("R1", "grant slot 0", 32'(grant), 32'(6'b001000));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule